// File: doc/BRIEF.md
# System-Management Interrupt Entry Controller

This block sits between an asynchronous, active-low system-management interrupt pin and a processor core's interrupt sequencer. It brings the pin into the clock domain and turns each qualifying high-to-low transition into one service request. It presents that request to the core as a single-cycle entry pulse at an instruction boundary, and never inside a locked bus sequence. The same boundary logic also grants ordinary NMI requests, and SMI always wins when both could be taken.

After an entry, the block blocks further entries until the core signals that the resume instruction has completed. While entries are blocked it keeps at most one further request. That request is granted at the first boundary after the resume, so the second handler follows the first with no application instruction between them. A management-active output tells the system that the core is in management mode. It rises only once the core has no outstanding writes, and it drops at the resume. There is no interrupt-enable input: the request cannot be masked by software. All pins are plain control signals with no handshake.

Top module: `sysmgmt_irq_ctrl`

## Requirements
- R1: When smi_n is first sampled low at rising edge e, and the edge detector is armed, take_smi can assert in the cycle that follows edge e+2. A low level lasting a single clock is enough.
- R2: Holding smi_n low for any number of clocks produces exactly one entry.
- R3: After a recognized fall, the detector re-arms only once smi_n has been sampled high on REARM_CLKS (default 4) consecutive edges. A fall that comes after fewer high samples is ignored.
- R4: take_smi and take_nmi are asserted only in a cycle with instr_boundary=1 and bus_locked=0. Each entry lasts one cycle.
- R5: When an SMI can be taken in the same cycle as nmi_req=1, take_smi=1 and take_nmi=0. take_nmi is granted whenever nmi_req=1 at a usable boundary and no SMI can be taken, including while in management mode.
- R6: After take_smi, no further take_smi occurs until rsm_done has been sampled high.
- R7: While entry is blocked, at most one request is kept pending. Any further falls are dropped.
- R8: A pending request is granted in the cycle right after the edge that samples rsm_done=1, provided that cycle is a usable boundary.
- R9: smiact rises at the first edge after the entry edge that samples writes_pending=0. It falls at the edge that samples rsm_done=1.
- R10: Reset clears all outputs, the pending request and the block, treats the pin as high, and leaves the detector armed, so the first fall after reset is recognized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smi_n | input | 1 | Asynchronous management interrupt pin, active low |
| nmi_req | input | 1 | Pending non-maskable interrupt, level |
| instr_boundary | input | 1 | Core is at an instruction boundary this cycle |
| bus_locked | input | 1 | A locked bus sequence is in progress |
| writes_pending | input | 1 | Core still has posted writes outstanding |
| rsm_done | input | 1 | One-cycle pulse: resume from management mode completed |
| take_smi | output | 1 | One-cycle grant of management interrupt entry |
| take_nmi | output | 1 | One-cycle grant of NMI entry |
| smiact | output | 1 | Core is operating in management mode |

## Verification
The assertions check on every cycle several rules that span the modules. A recognized fall never repeats on the next cycle and always follows a high sample. An entry immediately blocks further entries, and an entry is never two cycles long. smiact rises only after a drained cycle, stays inside management mode and drops after a resume. Some rules depend on the stimulus history, and only the bench's sweeps can show them: exact entry latency, re-arm gap lengths from one to six clocks, pulse widths, drain delays, dropping of excess requests and back-to-back entry timing.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int SYNC_DEPTH_DEF = 2;
  localparam int REARM_CLKS_DEF = 4;

  typedef struct packed {
    logic pending;
    logic in_smm;
    logic active;
  } smi_state_t;
endpackage

// File: rtl/smi_pin_filter.sv
module smi_pin_filter #(
  parameter int SYNC_DEPTH = smi_pkg::SYNC_DEPTH_DEF,
  parameter int REARM_CLKS = smi_pkg::REARM_CLKS_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall_evt
);
  localparam int CW = (REARM_CLKS > 2) ? $clog2(REARM_CLKS) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(REARM_CLKS - 1);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  pin_s;
  logic [CW-1:0]         hi_cnt;
  logic                  armed;

  // synchronizer chain, idles high
  generate
    for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b1;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_s    = sync_q[SYNC_DEPTH-1];
  assign fall_evt = armed & ~pin_s;

  // count consecutive high samples, saturating one short of the gap
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= CNT_TOP;
      armed  <= 1'b1;
    end else begin
      if (!pin_s)              hi_cnt <= '0;
      else if (hi_cnt < CNT_TOP) hi_cnt <= hi_cnt + 1'b1;

      if (fall_evt)                              armed <= 1'b0;
      else if (!armed && pin_s && hi_cnt == CNT_TOP) armed <= 1'b1;
    end
  end

  AST_FALL_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !fall_evt); // R2
  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall_evt |-> $past(pin_s)); // R3
endmodule

// File: rtl/smi_entry_state.sv
module smi_entry_state (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_evt,
  input  logic                take_smi,
  input  logic                rsm_done,
  input  logic                writes_pending,
  output smi_pkg::smi_state_t st
);
  smi_pkg::smi_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      // a new fall beats the clear from an entry in the same cycle
      if (fall_evt)      st_q.pending <= 1'b1;
      else if (take_smi) st_q.pending <= 1'b0;

      if (take_smi)      st_q.in_smm <= 1'b1;
      else if (rsm_done) st_q.in_smm <= 1'b0;

      if (rsm_done)                            st_q.active <= 1'b0;
      else if (st_q.in_smm && !writes_pending) st_q.active <= 1'b1;
    end
  end

  assign st = st_q;

  AST_ACTIVE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q.active) |-> $past(!writes_pending)); // R9
  AST_ACTIVE_IN_SMM: assert property (@(posedge clk) disable iff (rst)
    st_q.active |-> st_q.in_smm); // R9
  AST_RESUME_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    rsm_done |=> !st_q.active); // R9
endmodule

// File: rtl/smi_boundary_arb.sv
module smi_boundary_arb (
  input  logic instr_boundary,
  input  logic bus_locked,
  input  logic smi_pending,
  input  logic smi_blocked,
  input  logic nmi_req,
  output logic take_smi,
  output logic take_nmi
);
  logic slot_ok;
  logic smi_ready;

  always_comb begin
    slot_ok   = instr_boundary & ~bus_locked;
    smi_ready = smi_pending & ~smi_blocked;
    take_smi  = slot_ok & smi_ready;
    take_nmi  = slot_ok & nmi_req & ~smi_ready;
  end
endmodule

// File: rtl/sysmgmt_irq_ctrl.sv
module sysmgmt_irq_ctrl #(
  parameter int SYNC_DEPTH = smi_pkg::SYNC_DEPTH_DEF,
  parameter int REARM_CLKS = smi_pkg::REARM_CLKS_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic smi_n,
  input  logic nmi_req,
  input  logic instr_boundary,
  input  logic bus_locked,
  input  logic writes_pending,
  input  logic rsm_done,
  output logic take_smi,
  output logic take_nmi,
  output logic smiact
);
  logic                fall_evt;
  smi_pkg::smi_state_t st;

  smi_pin_filter #(.SYNC_DEPTH(SYNC_DEPTH), .REARM_CLKS(REARM_CLKS)) u_pin (
    .clk      (clk),
    .rst      (rst),
    .pin_n    (smi_n),
    .fall_evt (fall_evt)
  );

  smi_entry_state u_state (
    .clk            (clk),
    .rst            (rst),
    .fall_evt       (fall_evt),
    .take_smi       (take_smi),
    .rsm_done       (rsm_done),
    .writes_pending (writes_pending),
    .st             (st)
  );

  smi_boundary_arb u_arb (
    .instr_boundary (instr_boundary),
    .bus_locked     (bus_locked),
    .smi_pending    (st.pending),
    .smi_blocked    (st.in_smm),
    .nmi_req        (nmi_req),
    .take_smi       (take_smi),
    .take_nmi       (take_nmi)
  );

  assign smiact = st.active;

  AST_ENTRY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    take_smi |=> st.in_smm); // R6
  AST_ENTRY_PULSE: assert property (@(posedge clk) disable iff (rst)
    take_smi |=> !take_smi); // R4
endmodule

// File: tb/test_sysmgmt_irq_ctrl.sv
module test_sysmgmt_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smi_n = 1'b1, nmi_req = 1'b0, instr_boundary = 1'b0;
  logic bus_locked = 1'b0, writes_pending = 1'b0, rsm_done = 1'b0;
  logic take_smi, take_nmi, smiact;

  int n_chk = 0, n_fail = 0, n_smi = 0, n_nmi = 0;

  always #2 clk = ~clk; // 250 MHz

  sysmgmt_irq_ctrl i_sysmgmt_irq_ctrl (
    .clk(clk), .rst(rst), .smi_n(smi_n), .nmi_req(nmi_req),
    .instr_boundary(instr_boundary), .bus_locked(bus_locked),
    .writes_pending(writes_pending), .rsm_done(rsm_done),
    .take_smi(take_smi), .take_nmi(take_nmi), .smiact(smiact)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; samples and counts grants with inputs still stable
  task automatic step();
    @(posedge clk);
    #1;
    if (take_smi) n_smi++;
    if (take_nmi) n_nmi++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input int w);
    smi_n = 1'b0;
    idle(w);
    smi_n = 1'b1;
  endtask

  task automatic resume();
    rsm_done = 1'b1;
    step();
    rsm_done = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    #1;
    chk("R10 take_smi after reset", take_smi, 0);
    chk("R10 take_nmi after reset", take_nmi, 0);
    chk("R10 smiact after reset", smiact, 0);

    // R1 latency, single-clock low, first fall after reset (R10)
    instr_boundary = 1'b1;
    smi_n = 1'b0;
    step();
    smi_n = 1'b1;
    chk("R1 no take after e1", take_smi, 0);
    step();
    chk("R1 no take after e2", take_smi, 0);
    step();
    chk("R1 take after e3", take_smi, 1);
    step();
    chk("R4 take is one cycle", take_smi, 0);
    chk("R9 smiact not yet", smiact, 0);
    step();
    chk("R9 smiact risen", smiact, 1);
    resume();
    chk("R9 smiact drops at resume", smiact, 0);
    idle(6);

    // R2 sweep of low widths
    for (int w = 1; w <= 6; w++) begin
      n_smi = 0;
      pulse(w);
      idle(10);
      chk($sformatf("R2 width %0d one entry", w), n_smi, 1);
      resume();
      idle(6);
    end

    // R9 sweep of drain delays
    for (int d = 0; d <= 4; d++) begin
      int rise;
      rise = (d == 0) ? 5 : 4 + d;
      writes_pending = 1'b1;
      smi_n = 1'b0;
      step();
      smi_n = 1'b1;
      step();
      step();
      if (d == 0) writes_pending = 1'b0;
      for (int k = 4; k <= 9; k++) begin
        step();
        chk($sformatf("R9 drain %0d cycle %0d", d, k), smiact, (k >= rise) ? 1 : 0);
        if (k - 3 == d) writes_pending = 1'b0;
      end
      writes_pending = 1'b0;
      resume();
      idle(6);
    end

    // R3 / R6 / R8 sweep of re-arm gaps
    for (int g = 1; g <= 6; g++) begin
      n_smi = 0;
      pulse(1);
      idle(g);
      pulse(1);
      idle(8);
      chk($sformatf("R6 gap %0d blocked", g), n_smi, 1);
      resume();
      chk($sformatf("R3 R8 gap %0d back-to-back", g), take_smi, (g >= 4) ? 1 : 0);
      step();
      chk($sformatf("R8 gap %0d single", g), take_smi, 0);
      if (g >= 4) resume();
      idle(6);
    end

    // R7 extra requests dropped while blocked
    n_smi = 0;
    pulse(1); idle(6);
    pulse(1); idle(5);
    pulse(1); idle(6);
    resume();
    chk("R7 one pending granted", take_smi, 1);
    step();
    resume();
    chk("R7 third request dropped", take_smi, 0);
    idle(6);
    chk("R7 total entries", n_smi, 2);

    // R4 boundary and lock gating
    n_smi = 0;
    instr_boundary = 1'b0;
    pulse(1); idle(6);
    chk("R4 no take off boundary", n_smi, 0);
    instr_boundary = 1'b1;
    bus_locked = 1'b1;
    #1;
    chk("R4 no take when locked", take_smi, 0);
    step();
    chk("R4 still held by lock", take_smi, 0);
    bus_locked = 1'b0;
    #1;
    chk("R4 take once unlocked", take_smi, 1);
    step();
    resume();
    idle(6);

    // R5 priority over NMI
    instr_boundary = 1'b0;
    nmi_req = 1'b1;
    pulse(1); idle(5);
    instr_boundary = 1'b1;
    #1;
    chk("R5 smi wins", take_smi, 1);
    chk("R5 nmi waits", take_nmi, 0);
    step();
    chk("R5 nmi in smm", take_nmi, 1);
    nmi_req = 1'b0;
    resume();
    nmi_req = 1'b1;
    #1;
    chk("R5 nmi alone", take_nmi, 1);
    chk("R5 no smi alone", take_smi, 0);
    nmi_req = 1'b0;
    idle(6);

    // R10 reset in management mode
    pulse(1); idle(6);
    chk("R10 smiact before reset", smiact, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R10 smiact cleared", smiact, 0);
    n_smi = 0;
    pulse(1); idle(6);
    chk("R10 armed after reset", n_smi, 1);

    summary();
    $finish;
  end
endmodule